// File: doc/BRIEF.md
# Token-Configurable Ring Pseudorandom Bit Generator

The block makes a maximal-length pseudorandom bit stream from a fixed ring of one-bit elastic stages. Each stage holds a bit and a valid flag, and a bit moves forward only into free space. The ring has two segments. The oldest bit of segment 1 is one tap and the oldest bit of segment 2 is the other. When both taps hold bits, a combine step XORs them. The result goes to the output and also re-enters segment 1. In the same step the segment 1 tap bit is copied into the head of segment 2.

The physical chain and its tap points never change. The logical feedback polynomial is set only by how many bits each segment holds. Putting k bits in segment 1 and N−k bits in segment 2 behaves as a Fibonacci register of order N with taps at k and N. A load strobe clears the ring and preloads the selected counts with ones. The output uses a valid/ready handshake. Configurations with few bits in a segment leave long bubbles, so the bit rate depends on the selected configuration.

Top module: `prbs_ring_gen`

## Requirements
- R1: After reset and before any load strobe, `outValid` stays low.
- R2: A load strobe clears every stage and places the selected counts of one-bits at the tail ends of the segments. `outValid` is high in the first cycle after the strobe edge, and the first bit is 0.
- R3: Select codes map to logical order and taps as follows: 0 → N=3 taps [3,2]; 1 → N=4 [4,3]; 2 → N=5 [5,3]; 3 → N=6 [6,5]; 4 → N=7 [7,4]; 5 → N=7 [7,6]. Bit j of the stream equals s[k] XOR s[N] of a Fibonacci register. That register starts as all ones and shifts each new bit into s[1].
- R4: The stream repeats with a period of 2^N−1. Within one period, exactly 2^(N−1) of the bits are ones.
- R5: Select codes 6 and 7 load the same configuration as code 0.
- R6: While `outValid` is high and `outReady` is low, the next cycle still has `outValid` high with the same `outBit`, and no bit is lost.
- R7: Between loads, each segment holds a constant number of valid bits, and a stage is never written while it still holds a bit.
- R8: A load strobe in the middle of a stream restarts the new configuration's sequence from its first bit.
- R9: With `outReady` held high, code 3 (one bit in segment 2) needs more cycles to emit 12 bits than code 2 (two bits in segment 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties the ring |
| cfgSel | input | 3 | Configuration select code |
| loadCfg | input | 1 | Clear-and-preload strobe |
| outReady | input | 1 | Consumer ready |
| outValid | output | 1 | Output bit available |
| outBit | output | 1 | Pseudorandom output bit |

## Verification
Two events can fall in the same cycle. A combine step can be due while the consumer holds back. A load strobe can also arrive while bits are still in flight inside both segments. The bench drives a ready pattern that drops one cycle in three. This forces stalls exactly when a bit is offered, and the bit held across each stall must match the one offered before it. It also reloads right after a stream of bits. The next stream is judged against a freshly seeded reference register, so any stale bit from the earlier configuration shows up as a mismatch.

// File: rtl/prbs_ring_pkg.sv
package prbs_ring_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic             load;
    logic             fire;
    logic [CNT_W-1:0] seg1Cnt;
    logic [CNT_W-1:0] seg2Cnt;
  } ringCtrl_t;
endpackage

// File: rtl/ring_seg.sv
module ring_seg #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] preCnt,
  input  logic             inValid,
  input  logic             inBit,
  input  logic             tailTake,
  output logic             headFree,
  output logic             tailValid,
  output logic             tailBit
);
  logic [DEPTH-1:0] valid, bits, moveVec, nextValid, nextBits;
  logic holeAbove;

  // A bit moves when it is valid and some stage ahead of it frees up this cycle
  always_comb begin
    holeAbove = tailTake;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      moveVec[i] = valid[i] && holeAbove;
      holeAbove  = holeAbove || !valid[i];
    end
  end

  always_comb begin
    nextValid[0] = (valid[0] && !moveVec[0]) || inValid;
    nextBits[0]  = inValid ? inBit : bits[0];
    for (int i = 1; i < DEPTH; i++) begin
      nextValid[i] = (valid[i] && !moveVec[i]) || moveVec[i-1];
      nextBits[i]  = moveVec[i-1] ? bits[i-1] : bits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      bits  <= '0;
    end else if (load) begin
      bits <= '1;
      for (int i = 0; i < DEPTH; i++)
        valid[i] <= (i >= DEPTH - int'(preCnt));
    end else begin
      valid <= nextValid;
      bits  <= nextBits;
    end
  end

  assign headFree  = !valid[0];
  assign tailValid = valid[DEPTH-1];
  assign tailBit   = bits[DEPTH-1];

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !load) |-> !valid[0]);

  // R7
  token_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $countones(valid) == $past($countones(valid)));

  // R2
  preload_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> ($countones(valid) == $past(int'(preCnt))) && valid[DEPTH-1]);
endmodule

// File: rtl/prbs_ring_ctrl.sv
module prbs_ring_ctrl
  import prbs_ring_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             loadCfg,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             outReady,
  input  logic             tail1Valid,
  input  logic             tail2Valid,
  input  logic             head1Free,
  input  logic             head2Free,
  output ringCtrl_t        ctrl,
  output logic             outValid
);
  logic [CNT_W-1:0] cnt1, cnt2;

  // Occupancy table: segment-1 count sets the inner tap, the total sets the order
  always_comb begin
    case (cfgSel)
      SEL_W'(1): begin cnt1 = CNT_W'(3); cnt2 = CNT_W'(1); end
      SEL_W'(2): begin cnt1 = CNT_W'(3); cnt2 = CNT_W'(2); end
      SEL_W'(3): begin cnt1 = CNT_W'(5); cnt2 = CNT_W'(1); end
      SEL_W'(4): begin cnt1 = CNT_W'(4); cnt2 = CNT_W'(3); end
      SEL_W'(5): begin cnt1 = CNT_W'(6); cnt2 = CNT_W'(1); end
      default:   begin cnt1 = CNT_W'(2); cnt2 = CNT_W'(1); end
    endcase
  end

  // Join: both taps present and both heads able to take the forked bits
  assign outValid     = tail1Valid && tail2Valid && head1Free && head2Free;
  assign ctrl.load    = loadCfg;
  assign ctrl.fire    = outValid && outReady && !loadCfg;
  assign ctrl.seg1Cnt = cnt1;
  assign ctrl.seg2Cnt = cnt2;
endmodule

// File: rtl/prbs_ring_dp.sv
module prbs_ring_dp
  import prbs_ring_pkg::*;
#(
  parameter int SEG1_DEPTH = 8,
  parameter int SEG2_DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  ringCtrl_t ctrl,
  output logic      tail1Valid,
  output logic      tail2Valid,
  output logic      head1Free,
  output logic      head2Free,
  output logic      outBit
);
  logic tail1Bit, tail2Bit, newBit;

  assign newBit = tail1Bit ^ tail2Bit;
  assign outBit = newBit;

  ring_seg #(.DEPTH(SEG1_DEPTH), .CNT_W(CNT_W)) seg1 (
    .clk(clk), .rst(rst), .load(ctrl.load), .preCnt(ctrl.seg1Cnt),
    .inValid(ctrl.fire), .inBit(newBit), .tailTake(ctrl.fire),
    .headFree(head1Free), .tailValid(tail1Valid), .tailBit(tail1Bit)
  );

  ring_seg #(.DEPTH(SEG2_DEPTH), .CNT_W(CNT_W)) seg2 (
    .clk(clk), .rst(rst), .load(ctrl.load), .preCnt(ctrl.seg2Cnt),
    .inValid(ctrl.fire), .inBit(tail1Bit), .tailTake(ctrl.fire),
    .headFree(head2Free), .tailValid(tail2Valid), .tailBit(tail2Bit)
  );
endmodule

// File: rtl/prbs_ring_gen.sv
module prbs_ring_gen
  import prbs_ring_pkg::*;
#(
  parameter int SEG1_DEPTH = 8,
  parameter int SEG2_DEPTH = 4,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             loadCfg,
  input  logic             outReady,
  output logic             outValid,
  output logic             outBit
);
  ringCtrl_t ctrl;
  logic t1V, t2V, h1F, h2F;

  prbs_ring_ctrl #(.SEL_W(SEL_W)) ctrlUnit (
    .loadCfg(loadCfg), .cfgSel(cfgSel), .outReady(outReady),
    .tail1Valid(t1V), .tail2Valid(t2V), .head1Free(h1F), .head2Free(h2F),
    .ctrl(ctrl), .outValid(outValid)
  );

  prbs_ring_dp #(.SEG1_DEPTH(SEG1_DEPTH), .SEG2_DEPTH(SEG2_DEPTH)) dpUnit (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .tail1Valid(t1V), .tail2Valid(t2V), .head1Free(h1F), .head2Free(h2F),
    .outBit(outBit)
  );

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && !loadCfg) |=> (outValid && $stable(outBit)));
endmodule

// File: tb/prbs_ring_gen_test.sv
`timescale 1ns/1ps
module prbs_ring_gen_test;
  logic clk = 1'b0, rst = 1'b1, loadCfg = 1'b0, outReady = 1'b0;
  logic [2:0] cfgSel = 3'd0;
  logic outValid, outBit;
  int checks = 0, errors = 0, cycle = 0;

  prbs_ring_gen uut (
    .clk(clk), .rst(rst), .cfgSel(cfgSel), .loadCfg(loadCfg),
    .outReady(outReady), .outValid(outValid), .outBit(outBit)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycle++;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tapsFor(input int code, output int n, output int k);
    case (code)
      1: begin n = 4; k = 3; end
      2: begin n = 5; k = 3; end
      3: begin n = 6; k = 5; end
      4: begin n = 7; k = 4; end
      5: begin n = 7; k = 6; end
      default: begin n = 3; k = 2; end
    endcase
  endtask

  task automatic doLoad(input int code);
    @(negedge clk);
    cfgSel = 3'(code);
    loadCfg = 1'b1;
    @(negedge clk);
    loadCfg = 1'b0;
  endtask

  // Load a code, then compare nBits against a reference Fibonacci register
  task automatic streamCheck(input int code, input int refCode, input int nBits,
                             input bit gappy, input string req, output int used);
    int n, k, period, got, guard, ones, start;
    logic [8:1] r;
    bit first, stalled, stallBit, rdy, expBit;
    tapsFor(refCode, n, k);
    period = (1 << n) - 1;
    r = '1;
    got = 0; guard = 0; ones = 0; stalled = 0; first = 0; stallBit = 0;
    doLoad(code);
    start = cycle;
    while (got < nBits && guard < 4000) begin
      rdy = gappy ? ((guard % 3) != 1) : 1'b1;
      outReady = rdy;
      if (stalled)
        check(outValid && outBit == stallBit, "R6 held bit", int'(outBit), int'(stallBit));
      stalled = 0;
      if (got == 0 && guard == 0)
        check(outValid && outBit == 1'b0, "R2 first bit after load", int'(outBit), 0);
      if (outValid) begin
        if (rdy) begin
          expBit = r[k] ^ r[n];
          check(outBit == expBit, req, int'(outBit), int'(expBit));
          for (int i = 8; i > 1; i--) r[i] = r[i-1];
          r[1] = expBit;
          if (got == 0) first = outBit;
          if (got < period) ones += int'(outBit);
          if (got == period)
            check(outBit == first, "R4 period repeat", int'(outBit), int'(first));
          got++;
        end else begin
          stalled = 1;
          stallBit = outBit;
        end
      end
      @(negedge clk);
      guard++;
    end
    outReady = 1'b0;
    check(got == nBits, "stream stalled", got, nBits);
    if (nBits > period)
      check(ones == (1 << (n - 1)), "R4 ones per period", ones, 1 << (n - 1));
    used = cycle - start;
  endtask

  task automatic testReset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1 idle after reset", int'(outValid), 0);
    end
  endtask

  task automatic testAllCodes();
    int n, k, used;
    for (int c = 0; c < 6; c++) begin
      tapsFor(c, n, k);
      streamCheck(c, c, (1 << n), 1'b0, "R3 sequence", used);
    end
  endtask

  task automatic testStall();
    int used;
    streamCheck(4, 4, 128, 1'b1, "R6 R3 stalled stream", used);
    streamCheck(1, 1, 16, 1'b1, "R6 R3 stalled stream", used);
  endtask

  task automatic testAlias();
    int used;
    streamCheck(6, 0, 8, 1'b0, "R5 code 6", used);
    streamCheck(7, 0, 8, 1'b0, "R5 code 7", used);
  endtask

  task automatic testReload();
    int used;
    streamCheck(2, 2, 10, 1'b1, "R3 pre-reload", used);
    // Ring still holds mixed bits; reload must restart cleanly (R8, R7)
    streamCheck(4, 4, 30, 1'b0, "R8 R7 after reload", used);
  endtask

  task automatic testRate();
    int c2, c3;
    streamCheck(2, 2, 12, 1'b0, "R3 rate run", c2);
    streamCheck(3, 3, 12, 1'b0, "R3 rate run", c3);
    check(c3 > c2, "R9 single-token segment slower", c3, c2 + 1);
  endtask

  initial begin
    testReset();
    testAllCodes();
    testStall();
    testAlias();
    testReload();
    testRate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule